// File: doc/BRIEF.md
# Unlock-Key Configuration Port Decoder

This block holds the power-up configuration logic of a legacy I/O-mapped adapter. After reset the adapter has no address window and drives no interrupt. A host enables it by writing a fixed five-byte unlock key to two fixed I/O ports, then one packed configuration byte. That byte turns the adapter on or off, selects its base address from an eight-entry table and selects an interrupt line.

The block watches a simple 8-bit write bus (address, data, strobe) and has a separate read channel. Once enabled, it reports a hit for each read that falls inside the 16-byte window at the selected base, together with the offset inside the window. It implements one register of its own, at window offset 9, which a host can use to probe for the adapter. Every read that is not a hit returns all ones, as a floating bus would.

Two parameters pick the variants. One picks the unlock key set, the other picks the base-address table.

Top module: `cfg_unlock_decoder`

## Requirements
- R1: After reset the adapter is disabled, `irq_line` is 0, `rd_hit` is 0 and `rd_data` is 0xFF. The register at offset 9 holds 0x00.
- R2: With the default parameters, the key is 0x59 on port 0x779, followed by 0xB9, 0xC5, 0xAE and 0xA6 on port 0x379. The next write to 0x379 is the configuration byte and takes effect at that clock edge: bit 7 sets `enabled`, bits 2:0 pick the base entry and bits 6:4 give the interrupt code. Bit 3 is ignored. The default table, index 0 to 7, is 0x280, 0x290, 0x300, 0x310, 0x330, 0x340, 0x348, 0x350. Once the configuration byte is taken, the tracker returns to idle.
- R3: While the tracker is partway through the key, a write to 0x379 whose data differs from the expected key byte returns the tracker to idle. The rest of the key and a configuration byte written after that have no effect.
- R4: A write to 0x779 with 0x59 restarts the key from its second byte, whatever the tracker's state. A write to 0x779 with any other value returns the tracker to idle.
- R5: Writes to 0x379 while the tracker is idle change nothing.
- R6: A configuration byte with bit 7 clear disables the adapter. From then on, reads of the former window give `rd_hit` = 0 and `rd_data` = 0xFF.
- R7: Interrupt code 0 gives `irq_line` = 0 (no interrupt). Code 2 gives line 9. Every other code c gives line c.
- R8: While the adapter is enabled, a read with `rd_en` high at an address from base to base+15 gives `rd_hit` = 1 and `rd_ofs` = address - base. Addresses base-1 and base+16 miss. Any miss gives `rd_ofs` = 0 and `rd_data` = 0xFF.
- R9: While the adapter is enabled, a write to offset 9 stores the data with bit 6 cleared: writing 0xC0 reads back as 0x80. A read at offset 9 returns the stored value.
- R10: Writes into the window while the adapter is disabled do not change the offset-9 register. The stored value is kept while the adapter is disabled and reappears after it is re-enabled.
- R11: A read in the same cycle as the configuration byte write is decoded against the old mapping. The new mapping applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 16 | Write I/O address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read I/O address |
| rd_data | output | 8 | Read data, 0xFF on a miss |
| rd_hit | output | 1 | Read falls inside the enabled window |
| rd_ofs | output | 4 | Offset of the read inside the window, 0 on a miss |
| enabled | output | 1 | Adapter enable from the last configuration byte |
| base_addr | output | 16 | Selected window base |
| irq_line | output | 4 | Selected interrupt line, 0 for none |

## Verification
The read channel is separate from the write bus, so a window read can land in the same cycle as the configuration byte that moves or disables the window. The same is true of a read at offset 9 in the cycle that writes offset 9. The bench drives both on one clock: it reads at the old base+9 while writing a configuration that moves the base. It expects a hit with the old register contents in that cycle. It then expects a miss at the old address and a hit at the new one in the next cycle. A behavioural model predicts every output on every clock, so any early or late switch of the mapping shows up as a mismatch.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;
    localparam int IO_AW          = 16;
    localparam int DATA_W         = 8;
    localparam int KEY_LEN        = 5;
    localparam int STEP_W         = $clog2(KEY_LEN + 1);
    localparam int TBL_N          = 8;
    localparam int IDX_W          = $clog2(TBL_N);
    localparam int CODE_W         = 3;
    localparam int IRQ_W          = 4;
    localparam int WIN_BYTES      = 16;
    localparam int OFS_W          = $clog2(WIN_BYTES);
    localparam int CTRL_OFS       = 9;
    localparam int CTRL_DROP_BIT  = 6;
    localparam int IRQ_ALIAS_CODE = 2;
    localparam int IRQ_ALIAS_LINE = 9;

    // Unlock key byte at position pos for key set sel
    function automatic logic [DATA_W-1:0] key_byte(input int sel, input int pos);
        logic [DATA_W-1:0] b;
        b = '0;
        if (sel == 0) begin
            case (pos)
                0: b = 8'h59;
                1: b = 8'hB9;
                2: b = 8'hC5;
                3: b = 8'hAE;
                4: b = 8'hA6;
                default: b = '0;
            endcase
        end else begin
            case (pos)
                0: b = 8'h0F;
                1: b = 8'h22;
                2: b = 8'hF0;
                3: b = 8'h20;
                4: b = 8'h80;
                default: b = '0;
            endcase
        end
        return b;
    endfunction

    // Window base for table set sel and entry idx
    function automatic logic [IO_AW-1:0] base_entry(input int sel, input logic [IDX_W-1:0] idx);
        logic [IO_AW-1:0] a;
        if (sel == 0) begin
            case (idx)
                3'd0: a = 16'h0280;
                3'd1: a = 16'h0290;
                3'd2: a = 16'h0300;
                3'd3: a = 16'h0310;
                3'd4: a = 16'h0330;
                3'd5: a = 16'h0340;
                3'd6: a = 16'h0348;
                default: a = 16'h0350;
            endcase
        end else begin
            case (idx)
                3'd0: a = 16'h0220;
                3'd1: a = 16'h0240;
                3'd2: a = 16'h0280;
                3'd3: a = 16'h02A0;
                3'd4: a = 16'h02C0;
                3'd5: a = 16'h0300;
                3'd6: a = 16'h0320;
                default: a = 16'h0340;
            endcase
        end
        return a;
    endfunction

    // Interrupt code to line number, one code aliased to a high line
    function automatic logic [IRQ_W-1:0] irq_of(input logic [CODE_W-1:0] code);
        if (code == CODE_W'(IRQ_ALIAS_CODE))
            return IRQ_W'(IRQ_ALIAS_LINE);
        return IRQ_W'(code);
    endfunction
endpackage

// File: rtl/cfg_key_tracker.sv
module cfg_key_tracker
    import cfg_unlock_pkg::*;
#(
    parameter int               KEY_SET    = 0,
    parameter logic [IO_AW-1:0] PORT_START = 16'h0779,
    parameter logic [IO_AW-1:0] PORT_STEP  = 16'h0379
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IO_AW-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cfg_stb,
    output logic              cfg_en,
    output logic [IDX_W-1:0]  cfg_idx,
    output logic [CODE_W-1:0] cfg_code
);
    typedef struct packed {
        logic [STEP_W-1:0] step;   // 0 idle, 1..KEY_LEN-1 bytes matched, KEY_LEN awaiting config
    } trk_t;

    trk_t trk_d, trk_q;
    logic stb_d;
    logic hit_start, hit_step, step_mid, step_ok;

    always_comb begin
        hit_start = wr_en && (wr_addr == PORT_START);
        hit_step  = wr_en && (wr_addr == PORT_STEP);
        step_mid  = (trk_q.step != '0) && (trk_q.step < STEP_W'(KEY_LEN));
        step_ok   = (wr_data == key_byte(KEY_SET, int'(trk_q.step)));
        trk_d     = trk_q;
        stb_d     = 1'b0;
        if (hit_start) begin
            trk_d.step = (wr_data == key_byte(KEY_SET, 0)) ? STEP_W'(1) : '0;
        end else if (hit_step) begin
            if (trk_q.step == STEP_W'(KEY_LEN)) begin
                stb_d      = 1'b1;
                trk_d.step = '0;
            end else if (step_mid) begin
                trk_d.step = step_ok ? trk_q.step + STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign cfg_stb  = stb_d;
    assign cfg_en   = wr_data[DATA_W-1];
    assign cfg_idx  = wr_data[IDX_W-1:0];
    assign cfg_code = wr_data[DATA_W-2 -: CODE_W];

    p_cfg_back_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stb |=> (trk_q.step == '0));

    p_mismatch_drops_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PORT_STEP && trk_q.step != '0 && trk_q.step < STEP_W'(KEY_LEN)
         && wr_data != key_byte(KEY_SET, int'(trk_q.step))) |=> (trk_q.step == '0));

    p_bad_start_drops_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PORT_START && wr_data != key_byte(KEY_SET, 0)) |=> (trk_q.step == '0));

    p_idle_stays_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.step == '0 && !(wr_en && wr_addr == PORT_START)) |=> (trk_q.step == '0));
endmodule

// File: rtl/cfg_map_regs.sv
module cfg_map_regs
    import cfg_unlock_pkg::*;
#(
    parameter int MAP_SET = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stb,
    input  logic              cfg_en,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CODE_W-1:0] cfg_code,
    output logic              enabled,
    output logic [IO_AW-1:0]  base_addr,
    output logic [IRQ_W-1:0]  irq_line
);
    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [CODE_W-1:0] code;
    } map_t;

    map_t map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (cfg_stb) begin
            map_d.en   = cfg_en;
            map_d.idx  = cfg_idx;
            map_d.code = cfg_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign enabled   = map_q.en;
    assign base_addr = base_entry(MAP_SET, map_q.idx);
    assign irq_line  = irq_of(map_q.code);

    p_map_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_stb |=> $stable(map_q));

    p_alias_code_never_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line != IRQ_W'(IRQ_ALIAS_CODE));
endmodule

// File: rtl/cfg_window.sv
module cfg_window
    import cfg_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enabled,
    input  logic [IO_AW-1:0]  base_addr,
    input  logic              wr_en,
    input  logic [IO_AW-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IO_AW-1:0]  rd_addr,
    output logic              rd_hit,
    output logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << CTRL_DROP_BIT);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
    } win_t;

    win_t win_d, win_q;
    logic [IO_AW-1:0] wr_diff, rd_diff;
    logic             wr_in, rd_in, ctrl_wr;

    always_comb begin
        wr_diff = wr_addr - base_addr;
        rd_diff = rd_addr - base_addr;
        wr_in   = enabled && (wr_addr >= base_addr) && (wr_diff < IO_AW'(WIN_BYTES));
        rd_in   = enabled && (rd_addr >= base_addr) && (rd_diff < IO_AW'(WIN_BYTES));
        ctrl_wr = wr_en && wr_in && (wr_diff[OFS_W-1:0] == OFS_W'(CTRL_OFS));
        win_d   = win_q;
        if (ctrl_wr) win_d.ctrl = wr_data & KEEP_MASK;
        rd_hit  = rd_en && rd_in;
        rd_ofs  = rd_hit ? rd_diff[OFS_W-1:0] : '0;
        rd_data = (rd_hit && rd_ofs == OFS_W'(CTRL_OFS)) ? win_q.ctrl : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    p_disabled_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> (!rd_hit && rd_data == '1));

    p_miss_reads_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rd_data == '1 && rd_ofs == '0));

    p_disabled_keeps_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> $stable(win_q));
endmodule

// File: rtl/cfg_unlock_decoder.sv
module cfg_unlock_decoder
    import cfg_unlock_pkg::*;
#(
    parameter int               KEY_SET    = 0,
    parameter int               MAP_SET    = 0,
    parameter logic [IO_AW-1:0] PORT_START = 16'h0779,
    parameter logic [IO_AW-1:0] PORT_STEP  = 16'h0379
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IO_AW-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IO_AW-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit,
    output logic [OFS_W-1:0]  rd_ofs,
    output logic              enabled,
    output logic [IO_AW-1:0]  base_addr,
    output logic [IRQ_W-1:0]  irq_line
);
    logic              cfg_stb, cfg_en;
    logic [IDX_W-1:0]  cfg_idx;
    logic [CODE_W-1:0] cfg_code;

    cfg_key_tracker #(
        .KEY_SET(KEY_SET), .PORT_START(PORT_START), .PORT_STEP(PORT_STEP)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_stb(cfg_stb), .cfg_en(cfg_en), .cfg_idx(cfg_idx), .cfg_code(cfg_code)
    );

    cfg_map_regs #(.MAP_SET(MAP_SET)) u_map (
        .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_en(cfg_en), .cfg_idx(cfg_idx),
        .cfg_code(cfg_code), .enabled(enabled), .base_addr(base_addr), .irq_line(irq_line)
    );

    cfg_window u_win (
        .clk(clk), .rst_n(rst_n), .enabled(enabled), .base_addr(base_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_ofs(rd_ofs), .rd_data(rd_data)
    );
endmodule

// File: tb/cfg_unlock_decoder_tb.sv
module cfg_unlock_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_hit;
    logic [3:0]  rd_ofs;
    logic        enabled;
    logic [15:0] base_addr;
    logic [3:0]  irq_line;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    localparam int P_GO  = 16'h0779;
    localparam int P_KEY = 16'h0379;
    int key [5] = '{8'h59, 8'hB9, 8'hC5, 8'hAE, 8'hA6};
    int tbl [8] = '{16'h280, 16'h290, 16'h300, 16'h310, 16'h330, 16'h340, 16'h348, 16'h350};

    // reference state
    int m_step, m_en, m_idx, m_code, m_ctrl;

    always #10 clk = ~clk;

    cfg_unlock_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit), .rd_ofs(rd_ofs),
        .enabled(enabled), .base_addr(base_addr), .irq_line(irq_line)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // reference model update
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_step <= 0; m_en <= 0; m_idx <= 0; m_code <= 0; m_ctrl <= 0;
        end else if (wr_en) begin
            if (int'(wr_addr) == P_GO) begin
                m_step <= (int'(wr_data) == key[0]) ? 1 : 0;
            end else if (int'(wr_addr) == P_KEY) begin
                if (m_step == 5) begin
                    m_en <= int'(wr_data[7]); m_idx <= int'(wr_data[2:0]);
                    m_code <= int'(wr_data[6:4]); m_step <= 0;
                end else if (m_step != 0) begin
                    m_step <= (int'(wr_data) == key[m_step]) ? m_step + 1 : 0;
                end
            end else if (m_en != 0 && int'(wr_addr) == tbl[m_idx] + 9) begin
                m_ctrl <= int'(wr_data) & 8'hBF;
            end
        end
    end

    // per-clock comparison, away from the edge
    always @(negedge clk) begin
        #6;
        if (rst_n && !finished) begin
            int eb, ehit, eofs, erd, ra;
            eb   = tbl[m_idx];
            ra   = int'(rd_addr);
            ehit = (rd_en && m_en != 0 && ra >= eb && ra < eb + 16) ? 1 : 0;
            eofs = ehit ? ra - eb : 0;
            erd  = (ehit && eofs == 9) ? m_ctrl : 8'hFF;
            chk("R2", "enabled", int'(enabled), m_en);
            chk("R2", "base_addr", int'(base_addr), eb);
            chk("R7", "irq_line", int'(irq_line), (m_code == 2) ? 9 : m_code);
            chk("R8", "rd_hit", int'(rd_hit), ehit);
            chk("R8", "rd_ofs", int'(rd_ofs), eofs);
            chk("R9", "rd_data", int'(rd_data), erd);
        end
    end

    task automatic cyc(input bit w, input int wa, input int wd, input bit r, input int ra);
        @(negedge clk);
        wr_en = w; wr_addr = 16'(wa); wr_data = 8'(wd);
        rd_en = r; rd_addr = 16'(ra);
        #6;
    endtask

    task automatic wr(input int a, input int d);
        cyc(1'b1, a, d, 1'b0, 0);
    endtask

    task automatic rd(input int a);
        cyc(1'b0, 0, 0, 1'b1, a);
    endtask

    task automatic unlock();
        wr(P_GO, key[0]);
        for (int i = 1; i < 5; i++) wr(P_KEY, key[i]);
    endtask

    task automatic configure(input int c);
        unlock();
        wr(P_KEY, c);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        rd(16'h289);
        chk("R1", "enabled after reset", int'(enabled), 0);
        chk("R1", "irq after reset", int'(irq_line), 0);
        chk("R1", "rd_hit after reset", int'(rd_hit), 0);
        chk("R1", "rd_data after reset", int'(rd_data), 8'hFF);

        // R2 / R7: code 2 index 1
        configure(8'hA1);
        rd(16'h299);
        chk("R2", "enabled", int'(enabled), 1);
        chk("R2", "base idx1", int'(base_addr), 16'h290);
        chk("R7", "code 2 -> line 9", int'(irq_line), 9);
        chk("R1", "offset 9 reset value", int'(rd_data), 8'h00);

        // R8 window sweep
        for (int a = 16'h28E; a <= 16'h2A1; a++) rd(a);
        rd(16'h28F); chk("R8", "base-1 miss", int'(rd_hit), 0);
        rd(16'h290); chk("R8", "base hit", int'(rd_hit), 1);
        chk("R8", "base ofs", int'(rd_ofs), 0);
        rd(16'h29F); chk("R8", "base+15 ofs", int'(rd_ofs), 15);
        rd(16'h2A0); chk("R8", "base+16 miss", int'(rd_hit), 0);
        chk("R8", "miss data", int'(rd_data), 8'hFF);

        // R9 presence probe
        wr(16'h299, 8'hC0);
        rd(16'h299); chk("R9", "probe readback", int'(rd_data), 8'h80);

        // R3 mismatch mid-key
        wr(P_GO, key[0]); wr(P_KEY, key[1]); wr(P_KEY, 8'h00);
        wr(P_KEY, key[3]); wr(P_KEY, key[4]); wr(P_KEY, 8'h87);
        rd(16'h299);
        chk("R3", "base kept", int'(base_addr), 16'h290);
        chk("R3", "irq kept", int'(irq_line), 9);

        // R4 bad start value, then restart mid-key
        wr(P_GO, key[0]); wr(P_KEY, key[1]); wr(P_GO, 8'h00);
        wr(P_KEY, key[2]); wr(P_KEY, key[3]); wr(P_KEY, key[4]); wr(P_KEY, 8'h87);
        rd(16'h299);
        chk("R4", "bad start ignored", int'(base_addr), 16'h290);
        wr(P_GO, key[0]); wr(P_KEY, key[1]); wr(P_KEY, key[2]);
        configure(8'hB3);
        rd(16'h319);
        chk("R4", "restart base", int'(base_addr), 16'h310);
        chk("R4", "restart irq", int'(irq_line), 3);

        // R5 idle writes to key port
        wr(P_KEY, 8'h80); wr(P_KEY, 8'h00);
        rd(16'h319);
        chk("R5", "idle base", int'(base_addr), 16'h310);
        chk("R5", "idle enabled", int'(enabled), 1);

        // R6 disable (bit 3 set, ignored)
        configure(8'h0B);
        rd(16'h319);
        chk("R6", "disabled", int'(enabled), 0);
        chk("R6", "disabled miss", int'(rd_hit), 0);
        chk("R6", "disabled data", int'(rd_data), 8'hFF);

        // R10 writes while disabled ignored
        wr(16'h319, 8'h11);
        configure(8'h83);
        rd(16'h319);
        chk("R10", "ctrl kept", int'(rd_data), 8'h80);

        // R11 config write and read in one cycle
        unlock();
        cyc(1'b1, P_KEY, 8'hF7, 1'b1, 16'h319);
        chk("R11", "same-cycle hit old map", int'(rd_hit), 1);
        chk("R11", "same-cycle data old map", int'(rd_data), 8'h80);
        rd(16'h319);
        chk("R11", "old window gone", int'(rd_hit), 0);
        rd(16'h359);
        chk("R11", "new window data", int'(rd_data), 8'h80);
        chk("R7", "code 7", int'(irq_line), 7);

        // R7 / R2 every code and index
        for (int c = 0; c < 8; c++) begin
            configure(8'h80 | (c << 4) | c);
            rd(tbl[c] + 9);
            chk("R7", "irq map", int'(irq_line), (c == 2) ? 9 : c);
            chk("R2", "table entry", int'(base_addr), tbl[c]);
        end
        configure(8'h8D);
        rd(16'h349);
        chk("R2", "bit 3 ignored", int'(base_addr), 16'h340);
        chk("R7", "code 0 none", int'(irq_line), 0);

        cyc(1'b0, 0, 0, 1'b0, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule